// File: doc/BRIEF.md
# Two-Threshold Strip Clusteriser

The block scans corrected strip samples that arrive one per valid cycle in channel order. For each sample it decides whether the strip is below noise, at inclusion level or at seed level. It does this by comparing the sample with two per-strip thresholds. The caller fetches these thresholds from its own calibration store and presents them alongside each sample.

Each run of adjacent strips above their inclusion thresholds forms a candidate cluster. A run is cut into pieces of at most five strips. A candidate is published only if at least one of its strips passed its seed threshold. Each published cluster carries:
- the address of its first strip,
- its strip count,
- the raw sample of every member,
- a charge-weighted centre in fixed point with three fractional bits.

The block closes a cluster in one of three ways:
- on the first strip that fails inclusion,
- when the five-strip limit is reached,
- on the sample flagged as the last channel of the stream.

The record appears on the output one cycle after the sample that closed it.

Top module: `strip_clusteriser`

## Requirements
- R1: After synchronous reset, and until a cluster closes, `out_valid` is 0.
- R2: A sample qualifies as seed only when strictly greater than its seed threshold. An isolated seed strip gives a one-strip cluster whose centre equals its address times 8.
- R3: A strip qualifies for inclusion only when its sample is strictly greater than its inclusion threshold. Qualifying strips adjacent to a seed join the cluster, on either side of it, and `out_first` is the address of the first member.
- R4: A run of qualifying strips with no seed-level member produces no output.
- R5: A cluster closes at the first strip that fails inclusion, and that strip is not a member.
- R6: A cluster holds at most 5 strips and closes when the fifth joins. After such a close, a following strip opens a new cluster only if it is seed level. Inclusion-only strips are dropped until a strip fails inclusion or a seed arrives.
- R7: A sample with `in_last` set closes any open cluster. That sample is a member if it qualifies. The next stream starts with no history.
- R8: `out_centre` equals first·8 + floor((16·Σ i·q_i + Σ q_i) / (2·Σ q_i)), where i is the offset of a member within the cluster. This is the centre rounded half up to 1/8 strip.
- R9: `out_adc` holds member i in bits [6i+5:6i], and slots at or beyond `out_size` are zero. `out_size` is the member count.
- R10: The record appears in the cycle right after the sample that closes it, and there is at most one record per sample.
- R11: A sample equal to a threshold does not pass that threshold.
- R12: Thresholds are taken per sample, so strips with equal samples can be classed differently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_addr | input | ADDR_W | Channel address of the sample |
| in_adc | input | ADC_W | Corrected sample value |
| in_seed_thr | input | ADC_W | Seed threshold of this strip |
| in_incl_thr | input | ADC_W | Inclusion threshold of this strip |
| in_last | input | 1 | Sample is the last channel of the stream |
| out_valid | output | 1 | Cluster record valid |
| out_first | output | ADDR_W | Address of first member strip |
| out_size | output | clog2(MAX_LEN+1) | Member count |
| out_adc | output | MAX_LEN·ADC_W | Member samples, slot 0 lowest |
| out_centre | output | ADDR_W+FRAC_W | Centre, FRAC_W fractional bits |

## Verification
The hardest situation to reach is the state right after a five-strip close. The same inclusion-level sample is dropped there, yet it would open a cluster anywhere else. The state also has to be left again, either through a below-inclusion strip or through a seed.

The bench reaches this state, together with every other ordering, by sweeping all 3^7 level patterns over seven-strip streams. Thresholds and samples vary per strip, and some samples sit exactly on a threshold. Idle bubbles are inserted inside some streams. Each stream is compared against an arithmetic model of the rules above.

// File: rtl/clus_pkg.sv
package clus_pkg;
    localparam int ADDR_W_DEF = 11;
    localparam int ADC_W_DEF  = 6;
    localparam int MAX_LEN_DEF = 5;
    localparam int FRAC_W_DEF = 3;

    typedef enum logic [1:0] {
        LVL_BELOW = 2'd0,
        LVL_INCL  = 2'd1,
        LVL_SEED  = 2'd2
    } strip_lvl_e;

    typedef struct packed {
        logic open;
        logic seeded;
        logic blocked;
    } clus_flags_t;
endpackage

// File: rtl/clus_grade.sv
module clus_grade
    import clus_pkg::*;
#(
    parameter int ADC_W = ADC_W_DEF
) (
    input  logic [ADC_W-1:0] adc,
    input  logic [ADC_W-1:0] seed_thr,
    input  logic [ADC_W-1:0] incl_thr,
    output strip_lvl_e       lvl
);
    always_comb begin
        if (adc > seed_thr)      lvl = LVL_SEED;
        else if (adc > incl_thr) lvl = LVL_INCL;
        else                     lvl = LVL_BELOW;
    end
endmodule

// File: rtl/clus_track.sv
module clus_track
    import clus_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int ADC_W   = ADC_W_DEF,
    parameter int MAX_LEN = MAX_LEN_DEF,
    parameter int CNT_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic [ADC_W-1:0]         in_adc,
    input  strip_lvl_e               lvl,
    output logic                     emit,
    output logic [ADDR_W-1:0]        rec_first,
    output logic [CNT_W-1:0]         rec_size,
    output logic [MAX_LEN*ADC_W-1:0] rec_adc
);
    clus_flags_t       flg, flg_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ADDR_W-1:0] first, first_n;
    logic [ADC_W-1:0]  slot   [MAX_LEN];
    logic [ADC_W-1:0]  slot_n [MAX_LEN];
    logic              take, start, fin;

    always_comb begin
        flg_n   = flg;
        cnt_n   = cnt;
        first_n = first;
        slot_n  = slot;
        take    = 1'b0;
        start   = 1'b0;
        fin     = 1'b0;
        if (in_valid) begin
            if (flg.open) begin
                if (lvl == LVL_BELOW) fin = 1'b1;
                else                  take = 1'b1;
            end else if (lvl == LVL_SEED || (lvl == LVL_INCL && !flg.blocked)) begin
                start = 1'b1;
                take  = 1'b1;
            end else if (lvl == LVL_BELOW) begin
                flg_n.blocked = 1'b0;
            end
            if (start) begin
                flg_n   = '{open: 1'b1, seeded: 1'b0, blocked: 1'b0};
                cnt_n   = '0;
                first_n = in_addr;
                for (int k = 0; k < MAX_LEN; k++) slot_n[k] = '0;
            end
            if (take) begin
                for (int k = 0; k < MAX_LEN; k++)
                    if (CNT_W'(k) == cnt_n) slot_n[k] = in_adc;
                cnt_n = cnt_n + 1'b1;
                if (lvl == LVL_SEED) flg_n.seeded = 1'b1;
                if (cnt_n == CNT_W'(MAX_LEN)) begin
                    fin           = 1'b1;
                    flg_n.blocked = 1'b1;
                end
            end
            if (in_last) begin
                fin           = flg_n.open;
                flg_n.blocked = 1'b0;
            end
            if (fin) flg_n.open = 1'b0;
        end
    end

    assign emit      = fin && flg_n.seeded;
    assign rec_first = first_n;
    assign rec_size  = cnt_n;

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_pack
        assign rec_adc[g*ADC_W +: ADC_W] = slot_n[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg   <= '0;
            cnt   <= '0;
            first <= '0;
            for (int k = 0; k < MAX_LEN; k++) slot[k] <= '0;
        end else begin
            flg   <= flg_n;
            cnt   <= cnt_n;
            first <= first_n;
            slot  <= slot_n;
        end
    end

    // R6
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_LEN));

    // R5
    open_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        flg.open |-> (cnt != '0));
endmodule

// File: rtl/clus_centre.sv
module clus_centre
    import clus_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int ADC_W   = ADC_W_DEF,
    parameter int MAX_LEN = MAX_LEN_DEF,
    parameter int FRAC_W  = FRAC_W_DEF,
    parameter int CNT_W   = 3
) (
    input  logic [ADDR_W-1:0]        first,
    input  logic [MAX_LEN*ADC_W-1:0] adcs,
    output logic [ADDR_W+FRAC_W-1:0] centre
);
    localparam int SUM_W = ADC_W + 2*CNT_W + FRAC_W + 2;

    logic [SUM_W-1:0] sq, siq, num, den, frac;

    always_comb begin
        sq  = '0;
        siq = '0;
        for (int k = 0; k < MAX_LEN; k++) begin
            sq  = sq + SUM_W'(adcs[k*ADC_W +: ADC_W]);
            siq = siq + SUM_W'(k) * SUM_W'(adcs[k*ADC_W +: ADC_W]);
        end
        num  = (siq << (FRAC_W + 1)) + sq;
        den  = sq << 1;
        frac = (den == '0) ? '0 : num / den;
    end

    assign centre = {first, {FRAC_W{1'b0}}} + (ADDR_W+FRAC_W)'(frac);
endmodule

// File: rtl/strip_clusteriser.sv
module strip_clusteriser
    import clus_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int ADC_W   = ADC_W_DEF,
    parameter int MAX_LEN = MAX_LEN_DEF,
    parameter int FRAC_W  = FRAC_W_DEF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [ADDR_W-1:0]                in_addr,
    input  logic [ADC_W-1:0]                 in_adc,
    input  logic [ADC_W-1:0]                 in_seed_thr,
    input  logic [ADC_W-1:0]                 in_incl_thr,
    input  logic                             in_last,
    output logic                             out_valid,
    output logic [ADDR_W-1:0]                out_first,
    output logic [$clog2(MAX_LEN+1)-1:0]     out_size,
    output logic [MAX_LEN*ADC_W-1:0]         out_adc,
    output logic [ADDR_W+FRAC_W-1:0]         out_centre
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int CEN_W = ADDR_W + FRAC_W;

    strip_lvl_e              lvl;
    logic                    emit;
    logic [ADDR_W-1:0]       rec_first;
    logic [CNT_W-1:0]        rec_size;
    logic [MAX_LEN*ADC_W-1:0] rec_adc;
    logic [CEN_W-1:0]        rec_centre;

    clus_grade #(.ADC_W(ADC_W)) u_grade (
        .adc(in_adc), .seed_thr(in_seed_thr), .incl_thr(in_incl_thr), .lvl(lvl)
    );

    clus_track #(.ADDR_W(ADDR_W), .ADC_W(ADC_W), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_addr(in_addr), .in_adc(in_adc), .lvl(lvl),
        .emit(emit), .rec_first(rec_first), .rec_size(rec_size), .rec_adc(rec_adc)
    );

    clus_centre #(.ADDR_W(ADDR_W), .ADC_W(ADC_W), .MAX_LEN(MAX_LEN),
                  .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_centre (
        .first(rec_first), .adcs(rec_adc), .centre(rec_centre)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_first  <= '0;
            out_size   <= '0;
            out_adc    <= '0;
            out_centre <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_first  <= rec_first;
                out_size   <= rec_size;
                out_adc    <= rec_adc;
                out_centre <= rec_centre;
            end
        end
    end

    // R10
    emit_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R6
    size_cap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_size >= CNT_W'(1) && out_size <= CNT_W'(MAX_LEN)));

    // R8
    centre_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_centre >= {out_first, {FRAC_W{1'b0}}} &&
                       out_centre <= ((CEN_W'(out_first) + CEN_W'(out_size) - CEN_W'(1)) << FRAC_W)));

    // R3
    lead_member_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_adc[ADC_W-1:0] != '0));

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_pad
        // R9
        slot_pad_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_size <= CNT_W'(g)) |-> (out_adc[g*ADC_W +: ADC_W] == '0));
    end
endmodule

// File: tb/strip_clusteriser_bench.sv
module strip_clusteriser_bench;
    localparam int AW = 11;
    localparam int DW = 6;
    localparam int ML = 5;
    localparam int FW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [AW-1:0]   in_addr = '0;
    logic [DW-1:0]   in_adc = '0;
    logic [DW-1:0]   in_seed_thr = '0;
    logic [DW-1:0]   in_incl_thr = '0;
    logic            in_last = 1'b0;
    logic            out_valid;
    logic [AW-1:0]   out_first;
    logic [2:0]      out_size;
    logic [ML*DW-1:0] out_adc;
    logic [AW+FW-1:0] out_centre;

    strip_clusteriser u_strip_clusteriser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_adc(in_adc),
        .in_seed_thr(in_seed_thr), .in_incl_thr(in_incl_thr), .in_last(in_last),
        .out_valid(out_valid), .out_first(out_first), .out_size(out_size),
        .out_adc(out_adc), .out_centre(out_centre)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_in = 0;
    bit finished = 1'b0;

    int s_adc [16];
    int s_seed[16];
    int s_incl[16];
    int s_n;
    int s_base;
    bit s_bubble;

    int              got_first[$], got_size[$], got_centre[$], got_tag[$];
    logic [ML*DW-1:0] got_adc[$];
    int              exp_first[$], exp_size[$], exp_centre[$], exp_tag[$];
    logic [ML*DW-1:0] exp_adc[$];

    always @(posedge clk) if (!rst && in_valid) n_in <= n_in + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_first.push_back(int'(out_first));
            got_size.push_back(int'(out_size));
            got_centre.push_back(int'(out_centre));
            got_adc.push_back(out_adc);
            got_tag.push_back(n_in);
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic set_strip(int j, int a, int sd, int ic);
        s_adc[j] = a; s_seed[j] = sd; s_incl[j] = ic;
    endtask

    task automatic model(int n0);
        bit open = 0, blk = 0, seeded = 0;
        int cnt = 0, first = 0;
        logic [ML*DW-1:0] adcs = '0;
        for (int j = 0; j < s_n; j++) begin
            int a = s_adc[j];
            bit sd = a > s_seed[j];
            bit ic = a > s_incl[j];
            bit add = 0, fin = 0;
            if (open) begin
                if (ic) add = 1; else fin = 1;
            end else if (sd || (ic && !blk)) begin
                open = 1; cnt = 0; seeded = 0; first = s_base + j; adcs = '0; add = 1; blk = 0;
            end else if (!ic) blk = 0;
            if (add) begin
                adcs[cnt*DW +: DW] = DW'(a);
                cnt++;
                if (sd) seeded = 1;
                if (cnt == ML) begin fin = 1; blk = 1; end
            end
            if (j == s_n - 1) begin
                if (open) fin = 1;
                blk = 0;
            end
            if (fin && open) begin
                if (seeded) begin
                    int sq = 0, siq = 0;
                    for (int k = 0; k < ML; k++) begin
                        sq  += int'(adcs[k*DW +: DW]);
                        siq += k * int'(adcs[k*DW +: DW]);
                    end
                    exp_first.push_back(first);
                    exp_size.push_back(cnt);
                    exp_adc.push_back(adcs);
                    exp_centre.push_back(first * 8 + (16 * siq + sq) / (2 * sq));
                    exp_tag.push_back(n0 + j + 1);
                end
                open = 0;
            end
        end
    endtask

    task automatic run_stream(string tag);
        int n0 = n_in;
        model(n0);
        for (int j = 0; j < s_n; j++) begin
            if (s_bubble && j == 2) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid    = 1'b1;
            in_addr     = AW'(s_base + j);
            in_adc      = DW'(s_adc[j]);
            in_seed_thr = DW'(s_seed[j]);
            in_incl_thr = DW'(s_incl[j]);
            in_last     = (j == s_n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(got_first.size() == exp_first.size(), tag, "cluster count",
            got_first.size(), exp_first.size());
        for (int c = 0; c < got_first.size() && c < exp_first.size(); c++) begin
            chk(got_first[c] == exp_first[c], "R3", "first address", got_first[c], exp_first[c]);
            chk(got_size[c] == exp_size[c], "R6", "strip count", got_size[c], exp_size[c]);
            chk(got_adc[c] == exp_adc[c], "R9", "packed samples",
                longint'(got_adc[c]), longint'(exp_adc[c]));
            chk(got_centre[c] == exp_centre[c], "R8", "centre", got_centre[c], exp_centre[c]);
            chk(got_tag[c] == exp_tag[c], "R10", "closing sample index", got_tag[c], exp_tag[c]);
        end
        got_first.delete(); got_size.delete(); got_adc.delete(); got_centre.delete(); got_tag.delete();
        exp_first.delete(); exp_size.delete(); exp_adc.delete(); exp_centre.delete(); exp_tag.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        end

        s_bubble = 0;
        // R2: isolated seed
        s_n = 3; s_base = 100;
        set_strip(0, 3, 30, 10); set_strip(1, 40, 30, 10); set_strip(2, 2, 30, 10);
        run_stream("R2");

        // R5: closing strip excluded, trailing inclusion-only run dropped (R4)
        s_n = 5; s_base = 200;
        set_strip(0, 35, 30, 10); set_strip(1, 20, 30, 10); set_strip(2, 5, 30, 10);
        set_strip(3, 20, 30, 10); set_strip(4, 1, 30, 10);
        run_stream("R5");

        // R4: inclusion-only run
        s_n = 4; s_base = 300;
        set_strip(0, 15, 30, 10); set_strip(1, 25, 30, 10); set_strip(2, 30, 30, 10);
        set_strip(3, 0, 30, 10);
        run_stream("R4");

        // R7: cluster closed by the last flag
        s_n = 2; s_base = 400;
        set_strip(0, 20, 30, 10); set_strip(1, 50, 30, 10);
        run_stream("R7");

        // R6: long seed run split 5 + 2
        s_n = 7; s_base = 500;
        for (int j = 0; j < 7; j++) set_strip(j, 40 + j, 30, 10);
        run_stream("R6");

        // R6: after the limit, inclusion-only strips are dropped until a seed
        s_n = 9; s_base = 600;
        for (int j = 0; j < 5; j++) set_strip(j, 45, 30, 10);
        set_strip(5, 20, 30, 10); set_strip(6, 20, 30, 10);
        set_strip(7, 50, 30, 10); set_strip(8, 20, 30, 10);
        run_stream("R6");

        // R11: samples equal to thresholds
        s_n = 3; s_base = 700;
        set_strip(0, 30, 30, 10); set_strip(1, 10, 30, 10); set_strip(2, 30, 30, 10);
        run_stream("R11");

        // R12: equal samples, different per-strip thresholds
        s_n = 3; s_base = 800;
        set_strip(0, 20, 25, 15); set_strip(1, 20, 10, 5); set_strip(2, 20, 40, 30);
        run_stream("R12");

        // R3/R8: near-exhaustive sweep over level patterns
        for (int k = 0; k < 2187; k++) begin
            int code = k;
            s_n = 7;
            s_base = (k * 13) % 1500 + 8;
            s_bubble = k[0];
            for (int j = 0; j < 7; j++) begin
                int cls = code % 3;
                int sd = 20 + (k * 7 + j * 3) % 20;
                int ic = sd - 5 - ((k + j) % 6);
                int a;
                code = code / 3;
                if (cls == 0)      a = ic - ((k * 3 + j) % 3);
                else if (cls == 1) a = ic + 1 + ((k + j * 5) % (sd - ic));
                else               a = sd + 1 + ((k * 11 + j) % (63 - sd));
                set_strip(j, a, sd, ic);
            end
            run_stream("R3");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule